// File: doc/BRIEF.md
# Read-Address Unlock Sequence Detector

This block watches the accesses made to an asynchronous-style memory bus after they have been sampled into a synchronous clock domain. Each access arrives as a one-cycle strobe with a write flag, an output-enable flag and a 17-bit address. Reads still complete normally in the memory. In parallel, the detector looks for one exact run of six consecutive reads. The last address of that run selects one of four commands for the nonvolatile controller: save the array, reload the array, block automatic saving, or allow automatic saving again.

The first five addresses of every run are fixed and must come in order. The sixth address chooses the command. Only the low 16 address bits are compared. A write, a read without output enable, or a read to any other address breaks the run. While the nonvolatile controller reports that it is busy, the detector ignores the bus and stays idle. The block only raises one-cycle command pulses. Carrying out the commands is the controller's job.

Top module: `seqcmd_detector`

## Requirements
- R1: After reset, all four command outputs are low and the match progress is idle.
- R2: A run of counted reads to 4E38, B1C7, 83E0, 7C1F, 703F (hex) followed by a sixth counted read raises exactly one command output, for exactly one clock cycle, starting at the clock edge that samples the sixth read. The sixth address selects the command: 8FC0 gives `cmd_store`, 4C63 gives `cmd_recall`, 8B45 gives `cmd_inhibit_on` and 4B46 gives `cmd_inhibit_off`.
- R3: Address bit 16 takes no part in matching, so a run gives the same result whichever value that bit has on each step.
- R4: A write access breaks the run, even when its address is the expected one, and no command follows unless the run is started again from the beginning.
- R5: A step is counted only on a read that has `acc_oe` high. A read with `acc_oe` low breaks the run in the same way as a stray access.
- R6: A read to an address other than the expected one breaks the run. This includes a sixth address that is not one of the four command codes. No command is issued.
- R7: When a read to 4E38 breaks a run, it is counted as the first step of a new run. The next read to B1C7 therefore continues that new run.
- R8: While `nv_busy` is high, accesses are ignored and progress is forced back to idle. A run entered entirely during busy gives no command, and busy going high in the middle of a run cancels it.
- R9: Clock cycles without `acc_stb` neither advance nor break the run.
- R10: After a command has been issued the detector is idle, so a single further read to a command address gives no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_stb | input | 1 | One-cycle strobe marking a sampled bus access |
| acc_wr | input | 1 | High if the access is a write |
| acc_oe | input | 1 | High if output enable was active during the access |
| acc_addr | input | ADDR_W (17) | Access address |
| nv_busy | input | 1 | Nonvolatile controller busy |
| cmd_store | output | 1 | One-cycle pulse: save the array to nonvolatile cells |
| cmd_recall | output | 1 | One-cycle pulse: reload the array from nonvolatile cells |
| cmd_inhibit_on | output | 1 | One-cycle pulse: block automatic saving |
| cmd_inhibit_off | output | 1 | One-cycle pulse: allow automatic saving again |

## Verification
The bench builds the detector with its default 17-bit address. This means the unused top bit is a real input pin, so the bench can toggle it during a run and confirm that it is ignored. Because the prefix length and the four command codes are fixed at 16 bits, the bench can cover every break point: at an early step, at a late step and at the sixth step. It also runs the restart-on-first-address path and the case where busy goes high in the middle of a run.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;

    localparam int MATCH_W    = 16;
    localparam int PREFIX_LEN = 5;
    localparam int NUM_CMDS   = 4;
    localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

    // command vector bit positions
    localparam int CMD_STORE   = 0;
    localparam int CMD_RECALL  = 1;
    localparam int CMD_INH_ON  = 2;
    localparam int CMD_INH_OFF = 3;

    typedef struct packed {
        logic [STEP_W-1:0] step;
    } fsm_state_t;

    typedef struct packed {
        logic [NUM_CMDS-1:0] cmd;
    } pulse_state_t;

    function automatic logic [MATCH_W-1:0] prefix_code(input int idx);
        case (idx)
            0:       return 16'h4E38;
            1:       return 16'hB1C7;
            2:       return 16'h83E0;
            3:       return 16'h7C1F;
            4:       return 16'h703F;
            default: return '0;
        endcase
    endfunction

    function automatic logic [MATCH_W-1:0] cmd_code(input int idx);
        case (idx)
            CMD_STORE:   return 16'h8FC0;
            CMD_RECALL:  return 16'h4C63;
            CMD_INH_ON:  return 16'h8B45;
            CMD_INH_OFF: return 16'h4B46;
            default:     return '0;
        endcase
    endfunction

endpackage

// File: rtl/seqcmd_addr_match.sv
module seqcmd_addr_match
    import seqcmd_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic [PREFIX_LEN-1:0] prefix_hit,
    output logic [NUM_CMDS-1:0]   cmd_hit
);

    // only the low MATCH_W bits take part in comparison
    logic [MATCH_W-1:0] key;
    assign key = addr[MATCH_W-1:0];

    for (genvar i = 0; i < PREFIX_LEN; i++) begin : g_prefix
        assign prefix_hit[i] = (key == prefix_code(i));
    end

    for (genvar c = 0; c < NUM_CMDS; c++) begin : g_cmd
        assign cmd_hit[c] = (key == cmd_code(c));
    end

endmodule

// File: rtl/seqcmd_step_fsm.sv
module seqcmd_step_fsm
    import seqcmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stb,
    input  logic                  wr,
    input  logic                  oe,
    input  logic                  busy,
    input  logic [PREFIX_LEN-1:0] prefix_hit,
    input  logic [NUM_CMDS-1:0]   cmd_hit,
    output logic [STEP_W-1:0]     step_q,
    output logic [NUM_CMDS-1:0]   fire_d
);

    fsm_state_t cur_q, nxt_d;

    // decode of current step, one bit per prefix position
    logic [PREFIX_LEN-1:0] at_step;
    for (genvar i = 0; i < PREFIX_LEN; i++) begin : g_at
        assign at_step[i] = (cur_q.step == STEP_W'(i));
    end

    logic counted_rd;
    logic prefix_adv;
    logic last_step;

    always_comb begin
        counted_rd = stb && !wr && oe;
        prefix_adv = |(at_step & prefix_hit);
        last_step  = (cur_q.step == STEP_W'(PREFIX_LEN));
        nxt_d      = cur_q;
        fire_d     = '0;
        if (busy) begin
            nxt_d.step = '0;
        end else if (stb) begin
            if (counted_rd && prefix_adv) begin
                nxt_d.step = cur_q.step + STEP_W'(1);
            end else if (counted_rd && last_step && |cmd_hit) begin
                fire_d     = cmd_hit;
                nxt_d.step = '0;
            end else if (counted_rd && prefix_hit[0]) begin
                nxt_d.step = STEP_W'(1);
            end else begin
                nxt_d.step = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign step_q = cur_q.step;

    a_r8_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (step_q == '0));

    a_r6_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= STEP_W'(PREFIX_LEN));

    a_r4_write_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && wr) |=> (step_q == '0));

    a_r9_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb && !busy) |=> $stable(step_q));

endmodule

// File: rtl/seqcmd_pulse_reg.sv
module seqcmd_pulse_reg
    import seqcmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CMDS-1:0] fire_d,
    output logic [NUM_CMDS-1:0] cmd_q
);

    pulse_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.cmd = fire_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cmd_q = cur_q.cmd;

    a_r2_one_command: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_q));

    a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmd_q) |=> (cmd_q == '0));

endmodule

// File: rtl/seqcmd_detector.sv
module seqcmd_detector
    import seqcmd_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_stb,
    input  logic              acc_wr,
    input  logic              acc_oe,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              nv_busy,
    output logic              cmd_store,
    output logic              cmd_recall,
    output logic              cmd_inhibit_on,
    output logic              cmd_inhibit_off
);

    logic [PREFIX_LEN-1:0] prefix_hit;
    logic [NUM_CMDS-1:0]   cmd_hit;
    logic [NUM_CMDS-1:0]   fire_d;
    logic [NUM_CMDS-1:0]   cmd_q;
    logic [STEP_W-1:0]     step_q;

    seqcmd_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .addr       (acc_addr),
        .prefix_hit (prefix_hit),
        .cmd_hit    (cmd_hit)
    );

    seqcmd_step_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb        (acc_stb),
        .wr         (acc_wr),
        .oe         (acc_oe),
        .busy       (nv_busy),
        .prefix_hit (prefix_hit),
        .cmd_hit    (cmd_hit),
        .step_q     (step_q),
        .fire_d     (fire_d)
    );

    seqcmd_pulse_reg u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_d (fire_d),
        .cmd_q  (cmd_q)
    );

    assign cmd_store       = cmd_q[CMD_STORE];
    assign cmd_recall      = cmd_q[CMD_RECALL];
    assign cmd_inhibit_on  = cmd_q[CMD_INH_ON];
    assign cmd_inhibit_off = cmd_q[CMD_INH_OFF];

    // R5: a command only follows a counted read sampled while not busy
    a_r5_needs_counted_read: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire_d) |-> (acc_stb && !acc_wr && acc_oe && !nv_busy));

    // R2: a command is issued only from the final step of the run
    a_r2_from_last_step: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire_d) |-> (step_q == STEP_W'(PREFIX_LEN)));

endmodule

// File: tb/sim_seqcmd_detector.sv
module sim_seqcmd_detector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_stb = 1'b0;
    logic        acc_wr = 1'b0;
    logic        acc_oe = 1'b1;
    logic [16:0] acc_addr = '0;
    logic        nv_busy = 1'b0;
    logic        cmd_store, cmd_recall, cmd_inhibit_on, cmd_inhibit_off;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [15:0] PFX [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};
    localparam logic [15:0] C_STORE  = 16'h8FC0;
    localparam logic [15:0] C_RECALL = 16'h4C63;
    localparam logic [15:0] C_INHON  = 16'h8B45;
    localparam logic [15:0] C_INHOFF = 16'h4B46;
    // expected vector order: {inhibit_off, inhibit_on, recall, store}
    localparam logic [3:0] E_NONE = 4'b0000, E_STORE = 4'b0001, E_RECALL = 4'b0010,
                           E_INHON = 4'b0100, E_INHOFF = 4'b1000;

    always #2.5 clk = ~clk;

    seqcmd_detector u0 (
        .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_wr(acc_wr), .acc_oe(acc_oe),
        .acc_addr(acc_addr), .nv_busy(nv_busy), .cmd_store(cmd_store), .cmd_recall(cmd_recall),
        .cmd_inhibit_on(cmd_inhibit_on), .cmd_inhibit_off(cmd_inhibit_off)
    );

    function automatic logic [3:0] outs();
        return {cmd_inhibit_off, cmd_inhibit_on, cmd_recall, cmd_store};
    endfunction

    task automatic chk(input logic [3:0] got, input logic [3:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // one access; returns outputs one clock after it was sampled
    task automatic acc(input logic [16:0] a, input bit w, input bit oe, output logic [3:0] got);
        @(negedge clk);
        acc_stb = 1'b1; acc_wr = w; acc_oe = oe; acc_addr = a;
        @(negedge clk);
        acc_stb = 1'b0; acc_wr = 1'b0; acc_oe = 1'b1;
        got = outs();
    endtask

    task automatic rd(input logic [16:0] a, input string tag);
        logic [3:0] g;
        acc(a, 1'b0, 1'b1, g);
        chk(g, E_NONE, tag);
    endtask

    task automatic prefix(input bit hi);
        for (int i = 0; i < 5; i++) rd({hi, PFX[i]}, "R2 prefix step no pulse");
    endtask

    task automatic sixth(input logic [16:0] a, input logic [3:0] exp, input string tag);
        logic [3:0] g;
        acc(a, 1'b0, 1'b1, g);
        chk(g, exp, tag);
        @(negedge clk);
        chk(outs(), E_NONE, {tag, " pulse width"});
    endtask

    task automatic t_reset();
        chk(outs(), E_NONE, "R1 reset outputs low");
        sixth({1'b0, C_STORE}, E_NONE, "R1 idle after reset");
    endtask

    task automatic t_commands();
        prefix(1'b0); sixth({1'b0, C_STORE},  E_STORE,  "R2 store");
        prefix(1'b0); sixth({1'b0, C_RECALL}, E_RECALL, "R2 recall");
        prefix(1'b0); sixth({1'b0, C_INHON},  E_INHON,  "R2 inhibit on");
        prefix(1'b0); sixth({1'b0, C_INHOFF}, E_INHOFF, "R2 inhibit off");
    endtask

    task automatic t_bit16();
        prefix(1'b1); sixth({1'b1, C_RECALL}, E_RECALL, "R3 bit16 high");
        rd({1'b1, PFX[0]}, "R3 mix"); rd({1'b0, PFX[1]}, "R3 mix");
        rd({1'b1, PFX[2]}, "R3 mix"); rd({1'b0, PFX[3]}, "R3 mix");
        rd({1'b1, PFX[4]}, "R3 mix");
        sixth({1'b0, C_INHON}, E_INHON, "R3 bit16 mixed");
    endtask

    task automatic t_write_abort();
        logic [3:0] g;
        rd({1'b0, PFX[0]}, "R4"); rd({1'b0, PFX[1]}, "R4");
        acc({1'b0, PFX[2]}, 1'b1, 1'b1, g);
        chk(g, E_NONE, "R4 write step");
        rd({1'b0, PFX[3]}, "R4"); rd({1'b0, PFX[4]}, "R4");
        sixth({1'b0, C_STORE}, E_NONE, "R4 write aborts");
        prefix(1'b0);
        acc({1'b0, C_STORE}, 1'b1, 1'b1, g);
        chk(g, E_NONE, "R4 write as sixth");
    endtask

    task automatic t_oe_abort();
        logic [3:0] g;
        rd({1'b0, PFX[0]}, "R5"); rd({1'b0, PFX[1]}, "R5"); rd({1'b0, PFX[2]}, "R5");
        acc({1'b0, PFX[3]}, 1'b0, 1'b0, g);
        chk(g, E_NONE, "R5 oe low step");
        rd({1'b0, PFX[4]}, "R5");
        sixth({1'b0, C_RECALL}, E_NONE, "R5 oe low aborts");
    endtask

    task automatic t_stray();
        rd({1'b0, PFX[0]}, "R6"); rd({1'b0, 16'h1234}, "R6");
        rd({1'b0, PFX[1]}, "R6"); rd({1'b0, PFX[2]}, "R6");
        rd({1'b0, PFX[3]}, "R6"); rd({1'b0, PFX[4]}, "R6");
        sixth({1'b0, C_STORE}, E_NONE, "R6 stray read aborts");
        prefix(1'b0);
        sixth({1'b0, 16'hFFFF}, E_NONE, "R6 wrong sixth");
        sixth({1'b0, C_STORE}, E_NONE, "R6 idle after wrong sixth");
    endtask

    task automatic t_restart();
        rd({1'b0, PFX[0]}, "R7"); rd({1'b0, PFX[1]}, "R7");
        rd({1'b0, PFX[0]}, "R7 restart");
        rd({1'b0, PFX[1]}, "R7"); rd({1'b0, PFX[2]}, "R7");
        rd({1'b0, PFX[3]}, "R7"); rd({1'b0, PFX[4]}, "R7");
        sixth({1'b0, C_INHOFF}, E_INHOFF, "R7 restart at first address");
    endtask

    task automatic t_busy();
        nv_busy = 1'b1;
        prefix(1'b0);
        sixth({1'b0, C_STORE}, E_NONE, "R8 sequence during busy");
        nv_busy = 1'b0;
        rd({1'b0, PFX[0]}, "R8"); rd({1'b0, PFX[1]}, "R8"); rd({1'b0, PFX[2]}, "R8");
        @(negedge clk); nv_busy = 1'b1;
        @(negedge clk); nv_busy = 1'b0;
        rd({1'b0, PFX[3]}, "R8"); rd({1'b0, PFX[4]}, "R8");
        sixth({1'b0, C_STORE}, E_NONE, "R8 busy cancels run");
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 5; i++) begin
            rd({1'b0, PFX[i]}, "R9");
            repeat (3 + i) @(negedge clk);
            chk(outs(), E_NONE, "R9 idle gap");
        end
        sixth({1'b0, C_RECALL}, E_RECALL, "R9 gaps between steps");
    endtask

    task automatic t_after();
        prefix(1'b0); sixth({1'b0, C_STORE}, E_STORE, "R10 store");
        sixth({1'b0, C_STORE}, E_NONE, "R10 idle after command");
        prefix(1'b0); sixth({1'b0, C_INHON}, E_INHON, "R10 new full run");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_commands();
        t_bit16();
        t_write_abort();
        t_oe_abort();
        t_stray();
        t_restart();
        t_busy();
        t_gaps();
        t_after();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule